// File: doc/BRIEF.md
# Three-Wire Serial ADC Host Controller

This block is the host side of a link to a 12-bit successive-approximation converter that shares one data wire for both directions. When asked for a conversion, it pulls chip select low. It makes a serial clock from the faster system clock, using separate low and high phase lengths so that the converter's minimum pulse widths and maximum rate are met.

Five bits go out first: a start bit, then the four configuration bits. These are input mode, channel or polarity select, output bit order, and a keep-awake bit; clearing the keep-awake bit asks the converter to power down. The host then stops driving the shared wire while the fifth clock pulse is high. This is before the converter takes over the wire on the falling edge that follows.

The host drops the null bit that comes back first and shifts in the next twelve bits with the most significant bit first. It then raises chip select, shows the result zero-extended to 16 bits and pulses `done` for one cycle. Chip select stays high for a set minimum time before a new transaction can start.

The configuration inputs are sampled in the cycle the request is accepted. Requests that arrive while a transaction or its chip-select gap is in progress are dropped.

Top module: `adc3w_host`

## Requirements
- R1: While reset is held and just after it is released, `cs_n` is 1, and `sclk`, `sd_oe`, `busy`, `done` and `result` are all 0.
- R2: A `req` seen while idle drives `cs_n` low and `busy` high at the next clock edge, with `sclk` still low.
- R3: Every low phase of `sclk` lasts LO_CYC system cycles, counted from the fall of `cs_n` for the first phase. Every high phase lasts HI_CYC cycles.
- R4: The host sends five bits on `sd_o`, the first held before the first rising edge and each later bit changed only when `sclk` falls. In order they are: 1 (start), `cfg_single`, `cfg_odd`, `cfg_msb_first`, `cfg_stay_on`.
- R5: `sd_oe` is high from the fall of `cs_n` and drops while `sclk` is high in the fifth pulse. It is therefore 1 at the fifth rising edge and 0 at the fifth falling edge. It is never high while `cs_n` is high.
- R6: Each transaction has exactly 18 `sclk` pulses. `cs_n` rises in the cycle that the 18th pulse falls, and `sclk` stays low while `cs_n` is high.
- R7: At rising edges 7 to 18 the host samples `sd_i` (the sixth-edge null bit is dropped). It takes the value as bits 11 down to 0, and `result` becomes that value with bits 15:12 set to 0. The host only reads the first twelve bits, so the result is the same whatever bit order is requested.
- R8: `done` is high for exactly one cycle, the cycle in which `cs_n` rises and `result` is updated.
- R9: After a transaction, `cs_n` stays high for at least GAP_CYC cycles, and `busy` stays high through that gap.
- R10: A `req` that comes while `busy` is high starts no transaction, is not stored, and produces no extra `done`.
- R11: The configuration bits sent are the ones present when the request was accepted. Later changes to the `cfg_*` inputs do not affect the bits in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Conversion request, accepted only when idle |
| cfg_single | input | 1 | Input mode bit (1 = single-ended) |
| cfg_odd | input | 1 | Channel / polarity select bit |
| cfg_msb_first | input | 1 | Requested output bit order |
| cfg_stay_on | input | 1 | 0 requests converter power-down after this read |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| sd_o | output | 1 | Host value for the shared data wire |
| sd_oe | output | 1 | Host drives the shared data wire when 1 |
| sd_i | input | 1 | Value seen on the shared data wire |
| busy | output | 1 | Transaction or chip-select gap in progress |
| done | output | 1 | One-cycle strobe: `result` is new |
| result | output | 16 | Conversion code, right-justified and zero-extended |

## Verification
The hardest situation to reach from the ports is the handover of the shared wire. The bench's converter model records `sd_oe` at the fifth rising edge and at the fifth falling edge, and it counts any cycle in which both sides drive the wire. A second hard case is the minimum chip-select gap. To reach it, the bench holds `req` high across two transactions back to back, so the next one starts as early as the controller allows. The bench also changes the configuration inputs right after a request is accepted, and issues a request in the middle of a transaction. The converter model then shows which configuration bits actually went out, and whether any extra transaction was started.

// File: rtl/adc3w_pkg.sv
// Shared types and frame constants for the three-wire converter host.
// Assumes the converter frame: start + 4 config bits, one null bit, data.
package adc3w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } host_state_t;

    localparam int TX_BITS   = 5;  // start bit plus four configuration bits
    localparam int NULL_BITS = 1;  // turnaround bit returned before the data
endpackage

// File: rtl/adc3w_sclk_gen.sv
// Serial clock generator: while run is high, produces sclk with a low phase
// of LO_CYC and a high phase of HI_CYC system cycles, starting low.
// rise/fall are high in the first cycle of each new sclk level.
// Assumes LO_CYC >= 1 and HI_CYC >= 2.
module adc3w_sclk_gen #(
    parameter int LO_CYC = 125,
    parameter int HI_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int PMAX = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int CW   = $clog2(PMAX + 1);
    localparam logic [CW-1:0] LO_LAST = CW'(LO_CYC - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(HI_CYC - 1);

    logic [CW-1:0] phase_cnt;

    // Phase timer: counts out each level and toggles sclk at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_cnt <= '0;
            sclk      <= 1'b0;
            rise      <= 1'b0;
            fall      <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (!sclk) begin
                if (phase_cnt == LO_LAST) begin
                    phase_cnt <= '0;
                    sclk      <= 1'b1;
                    rise      <= 1'b1;
                end else begin
                    phase_cnt <= phase_cnt + 1'b1;
                end
            end else begin
                if (phase_cnt == HI_LAST) begin
                    phase_cnt <= '0;
                    sclk      <= 1'b0;
                    fall      <= 1'b1;
                end else begin
                    phase_cnt <= phase_cnt + 1'b1;
                end
            end
        end
    end

    // R3: edge strobes mark genuine level changes of sclk
    p_rise_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (sclk && !$past(sclk)));
    p_fall_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (!sclk && $past(sclk)));
    p_edge_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
endmodule

// File: rtl/adc3w_tx_shift.sv
// Transmit shifter for the shared data wire: loads the outgoing word,
// presents its MSB, shifts on each sclk fall, and owns the drive enable.
// Assumes load and shift never coincide.
module adc3w_tx_shift #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    input  logic         drop_oe,
    output logic         sd_o,
    output logic         sd_oe
);
    logic [W-1:0] tx_sr;

    // Shift register and drive-enable flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            sd_oe <= 1'b0;
        end else if (load) begin
            tx_sr <= load_word;
            sd_oe <= 1'b1;
        end else begin
            if (shift) begin
                tx_sr <= {tx_sr[W-2:0], 1'b0};
            end
            if (drop_oe) begin
                sd_oe <= 1'b0;
            end
        end
    end

    assign sd_o = tx_sr[W-1];

    // R5: the wire is only ever taken at the start of a transaction
    p_oe_from_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_oe) |-> $past(load));
endmodule

// File: rtl/adc3w_rx_shift.sv
// Receive shifter: collects W bits MSB-first from the shared wire when
// capture is high; cleared at the start of each transaction.
module adc3w_rx_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         capture,
    input  logic         sd_i,
    output logic [W-1:0] data
);
    // Shift in one sampled bit per capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            data <= '0;
        end else if (capture) begin
            data <= {data[W-2:0], sd_i};
        end
    end
endmodule

// File: rtl/adc3w_host.sv
// Three-wire converter host: sequences chip select, serial clock, the
// five-bit command, the turnaround of the shared wire, and the capture of
// the result. Assumes HI_CYC >= 2 so the wire is released inside the
// fifth high phase, and OUT_W >= RES_W.
module adc3w_host
    import adc3w_pkg::*;
#(
    parameter int LO_CYC  = 125,
    parameter int HI_CYC  = 125,
    parameter int GAP_CYC = 125,
    parameter int RES_W   = 12,
    parameter int OUT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             cfg_single,
    input  logic             cfg_odd,
    input  logic             cfg_msb_first,
    input  logic             cfg_stay_on,
    output logic             cs_n,
    output logic             sclk,
    output logic             sd_o,
    output logic             sd_oe,
    input  logic             sd_i,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] result
);
    localparam int FRAME = TX_BITS + NULL_BITS + RES_W;
    localparam int BCW   = $clog2(FRAME + 1);
    localparam int GCW   = $clog2(GAP_CYC + 1);
    localparam logic [BCW-1:0] LAST_PULSE = BCW'(FRAME);
    localparam logic [BCW-1:0] OE_PULSE   = BCW'(TX_BITS - 1);
    localparam logic [BCW-1:0] DATA_FIRST = BCW'(TX_BITS + NULL_BITS);
    localparam logic [GCW-1:0] GAP_LAST   = GCW'(GAP_CYC - 1);

    host_state_t      state;
    logic [BCW-1:0]   pulse_cnt;
    logic [GCW-1:0]   gap_cnt;
    logic             sck_rise;
    logic             sck_fall;
    logic             start_now;
    logic             in_xfer;
    logic [RES_W-1:0] rx_data;
    logic [TX_BITS-1:0] cmd_word;

    assign start_now = (state == ST_IDLE) && req;
    assign in_xfer   = (state == ST_XFER);
    assign busy      = (state != ST_IDLE);
    assign cmd_word  = {1'b1, cfg_single, cfg_odd, cfg_msb_first, cfg_stay_on};

    adc3w_sclk_gen #(
        .LO_CYC (LO_CYC),
        .HI_CYC (HI_CYC)
    ) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_xfer),
        .sclk  (sclk),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    adc3w_tx_shift #(
        .W (TX_BITS)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_now),
        .load_word (cmd_word),
        .shift     (in_xfer && sck_fall),
        .drop_oe   (in_xfer && sck_rise && (pulse_cnt == OE_PULSE)),
        .sd_o      (sd_o),
        .sd_oe     (sd_oe)
    );

    adc3w_rx_shift #(
        .W (RES_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_now),
        .capture (in_xfer && sck_rise && (pulse_cnt >= DATA_FIRST)),
        .sd_i    (sd_i),
        .data    (rx_data)
    );

    // Transaction sequencer: chip select, pulse counting, result, gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cs_n      <= 1'b1;
            pulse_cnt <= '0;
            gap_cnt   <= '0;
            done      <= 1'b0;
            result    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        state     <= ST_XFER;
                        cs_n      <= 1'b0;
                        pulse_cnt <= '0;
                    end
                end
                ST_XFER: begin
                    if (sck_rise) begin
                        pulse_cnt <= pulse_cnt + 1'b1;
                    end
                    if (sck_fall && (pulse_cnt == LAST_PULSE)) begin
                        state   <= ST_GAP;
                        cs_n    <= 1'b1;
                        done    <= 1'b1;
                        result  <= OUT_W'(rx_data);
                        gap_cnt <= '0;
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        state <= ST_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: the host never drives the wire outside a selected transaction
    p_oe_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> !cs_n);
    // R5: release happens inside a high phase of sclk
    p_oe_release_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_oe) |-> sclk);
    // R6: no clock pulses while deselected
    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R4: outgoing bit is steady while sclk stays high
    p_tx_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sd_o));
    // R8: done is a single-cycle strobe tied to deselection
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n));
    // R9: busy covers the whole selected period
    p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
    // R10: a transaction only begins from the idle state
    p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !$past(busy));
endmodule

// File: tb/adc3w_host_bench.sv
// Scoreboard bench with a behavioural converter on the shared wire.
module adc3w_host_bench;
    localparam int LO  = 5;
    localparam int HI  = 4;
    localparam int GAP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        cfg_single = 1'b0, cfg_odd = 1'b0, cfg_msb_first = 1'b0, cfg_stay_on = 1'b0;
    logic        cs_n, sclk, sd_o, sd_oe, sd_i, busy, done;
    logic [15:0] result;

    always #2 clk = ~clk;  // 250 MHz

    adc3w_host #(
        .LO_CYC (LO), .HI_CYC (HI), .GAP_CYC (GAP), .RES_W (12), .OUT_W (16)
    ) u_adc3w_host (
        .clk (clk), .rst_n (rst_n), .req (req),
        .cfg_single (cfg_single), .cfg_odd (cfg_odd),
        .cfg_msb_first (cfg_msb_first), .cfg_stay_on (cfg_stay_on),
        .cs_n (cs_n), .sclk (sclk), .sd_o (sd_o), .sd_oe (sd_oe), .sd_i (sd_i),
        .busy (busy), .done (done), .result (result)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    typedef struct packed {
        logic [4:0]  cfg;
        logic [15:0] res;
    } exp_t;
    exp_t sbq[$];

    // Converter model state
    logic        prev_cs = 1'b1, prev_sclk = 1'b0, prev_done = 1'b0;
    logic        dev_oe = 1'b0, dev_bit = 1'b0;
    logic [4:0]  dev_rx = '0, last_cfg = '0;
    logic [11:0] dev_code = '0, word;
    int dev_rises = 0, dev_falls = 0, run_len = 0, width_bad = 0, clash = 0;
    int hi_len = 0, min_gap = 1000, dones = 0, pushes = 0, cs_falls = 0, idx;
    bit oe_r5 = 0, oe_f5 = 1, seen_frame = 0;

    assign sd_i = dev_oe ? dev_bit : 1'b1;

    // Converter model and result monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                if (seen_frame && hi_len < min_gap) min_gap = hi_len;
                cs_falls++;
                dev_rises = 0; dev_falls = 0; dev_oe = 1'b0; run_len = 1;
                width_bad = 0; oe_r5 = 0; oe_f5 = 1; clash = 0;
            end else if (!prev_cs && cs_n) begin
                dev_oe = 1'b0; hi_len = 1; seen_frame = 1;
            end else if (cs_n) begin
                hi_len++;
            end else begin
                if (!prev_sclk && sclk) begin
                    if (run_len != LO) width_bad++;
                    run_len = 1; dev_rises++;
                    if (dev_rises <= 5) dev_rx = {dev_rx[3:0], sd_o};
                    if (dev_rises == 5) oe_r5 = sd_oe;
                end else if (prev_sclk && !sclk) begin
                    if (run_len != HI) width_bad++;
                    run_len = 1; dev_falls++;
                    if (dev_falls == 5) oe_f5 = sd_oe;
                    if (dev_falls >= 5) begin
                        dev_oe = 1'b1;
                        idx = dev_falls - 5;
                        word = dev_rx[0] ? dev_code : 12'hFFF;
                        dev_bit = (idx >= 1 && idx <= 12) ? word[12-idx] : 1'b0;
                    end
                end else begin
                    run_len++;
                end
                if (sd_oe && dev_oe) clash++;
            end

            if (done && prev_done) chk(0, "R8 done longer than one cycle", 1, 0);
            if (done) begin
                dones++;
                last_cfg = dev_rx;
                if (sbq.size() == 0) begin
                    chk(0, "R10 unexpected transaction", dones, pushes);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(result == e.res, "R7 result", int'(result), int'(e.res));
                    chk(dev_rx == e.cfg, "R4 command bits", int'(dev_rx), int'(e.cfg));
                    chk(dev_rises == 18, "R6 pulse count", dev_rises, 18);
                    chk(width_bad == 0, "R3 phase widths", width_bad, 0);
                    chk(oe_r5 && !oe_f5, "R5 turnaround", {oe_r5, oe_f5}, 2);
                    chk(clash == 0, "R5 wire contention", clash, 0);
                    chk(cs_n && busy, "R8 R9 done with cs high and busy", {cs_n, busy}, 3);
                end
            end
            prev_cs = cs_n; prev_sclk = sclk; prev_done = done;
        end
    end

    // Driver: waits for idle, pushes the expected item, issues the request
    task automatic run_conv(input logic s, input logic o, input logic m,
                            input logic p, input logic [11:0] code, input bit scramble);
        exp_t e;
        while (busy) @(negedge clk);
        dev_code = code;
        cfg_single = s; cfg_odd = o; cfg_msb_first = m; cfg_stay_on = p;
        e.cfg = {1'b1, s, o, m, p};
        e.res = p ? {4'h0, code} : 16'h0FFF;
        sbq.push_back(e); pushes++;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(!cs_n && busy && !sclk, "R2 select on request", {cs_n, busy, sclk}, 2);
        if (scramble) begin
            cfg_single = ~s; cfg_odd = ~o; cfg_msb_first = ~m; cfg_stay_on = ~p;
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        if (scramble) chk(last_cfg == e.cfg, "R11 config held", int'(last_cfg), int'(e.cfg));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && !sd_oe && !busy && !done && result == 0, "R1 in reset",
            {cs_n, sclk, sd_oe, busy, done}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !sclk && !sd_oe && !busy && !done && result == 0, "R1 after reset",
            {cs_n, sclk, sd_oe, busy, done}, 5'b10000);

        run_conv(1, 0, 1, 1, 12'hA5C, 0);
        run_conv(0, 1, 1, 1, 12'h001, 0);
        run_conv(1, 1, 0, 1, 12'h800, 0);   // LSB-first requested: R7 same value
        run_conv(0, 0, 1, 0, 12'h123, 0);   // power-down: all ones returned
        run_conv(1, 0, 1, 1, 12'hFFF, 0);
        run_conv(0, 0, 0, 1, 12'h000, 0);
        run_conv(1, 0, 1, 1, 12'h3C7, 1);   // R11: inputs change mid-frame

        // R10: request during a transaction is dropped
        run_conv(0, 1, 0, 1, 12'h5A5, 0);
        begin
            int d0;
            while (busy) @(negedge clk);
            d0 = dones;
            dev_code = 12'h6E1;
            cfg_single = 1; cfg_odd = 1; cfg_msb_first = 1; cfg_stay_on = 1;
            sbq.push_back({5'b11111, 16'h06E1}); pushes++;
            req = 1'b1; @(negedge clk); req = 1'b0;
            repeat (40) @(negedge clk);
            req = 1'b1; @(negedge clk); req = 1'b0;
            chk(!cs_n, "R10 frame continues", cs_n, 0);
            while (busy) @(negedge clk);
            repeat (20) @(negedge clk);
            chk(cs_n && !busy, "R10 no restart", {cs_n, busy}, 2);
            chk(dones == d0 + 1, "R10 single done", dones - d0, 1);
        end

        // R9: back-to-back requests give the minimum gap
        begin
            int f0;
            dev_code = 12'h9B4;
            cfg_single = 0; cfg_odd = 1; cfg_msb_first = 1; cfg_stay_on = 1;
            sbq.push_back({5'b10111, 16'h09B4}); sbq.push_back({5'b10111, 16'h09B4});
            pushes += 2;
            f0 = cs_falls;
            min_gap = 1000;
            req = 1'b1;
            while (cs_falls < f0 + 2) @(negedge clk);
            req = 1'b0;
            while (busy) @(negedge clk);
            repeat (5) @(negedge clk);
            chk(min_gap >= GAP && min_gap < 1000, "R9 cs high gap", min_gap, GAP);
        end

        chk(sbq.size() == 0 && dones == pushes, "R10 transaction count", dones, pushes);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule